// File: doc/BRIEF.md
# Memory-Card Host Interrupt and DMA Request Router

This block gathers the thirteen interrupt request sources of a memory-card host controller into one pending vector. It drives one CPU interrupt line and two DMA request lines, one for receive and one for transmit. Each source has its own set and clear pulse. A software-writable mask decides which pending sources reach the CPU line. When the controller works in DMA mode, the two FIFO service requests are taken off the CPU line and steered to the DMA request lines.

The block also owns the card clock start/stop control. A start write raises the clock-enabled status bit and withdraws the clock-off request. A stop write drops the status bit, raises the clock-off request and emits a one-cycle abort pulse that ends any transfer in progress. The control register is write-only: reading it returns zero.

All three request outputs are registered. Each follows the pending vector, the mask and the DMA-enable input with one cycle of latency.

Top module: `mci_irq_router`

## Requirements
- R1: While rst_ni is low, the pending vector, the mask, clk_en_o, xfer_abort_o, irq_o, rx_dma_req_o and tx_dma_req_o are all zero.
- R2: The request bits sit at these positions: data done 0, programming done 1, end of command 2, stop command 3, clock off 4, RX FIFO 5, TX FIFO 6, timer 7, data error 8, response error 9, read stalled 10, card interrupt 11, card acknowledge 12. A set pulse on bit k makes req_o[k] 1 on the next cycle. A clear pulse makes it 0. When both arrive in the same cycle, the set pulse wins.
- R3: A mask write stores mask_wdata_i[12:0] and ignores the upper bits. mask_o shows the stored value on the next cycle.
- R4: With dma_en_i low, irq_o equals, one cycle later, the OR of req_o & ~mask_o.
- R5: With dma_en_i high, bits 5 and 6 count as masked for irq_o, whatever the mask holds.
- R6: With dma_en_i high, rx_dma_req_o follows req_o[5] and tx_dma_req_o follows req_o[6], each one cycle later. With dma_en_i low, both lines are 0 one cycle later.
- R7: A clock-control write with bit 1 set and bit 0 clear sets clk_en_o and clears req_o[4] on the next cycle.
- R8: A clock-control write with bit 0 set clears clk_en_o, sets req_o[4] and pulses xfer_abort_o for exactly one cycle. Stop wins when bits 0 and 1 are both set.
- R9: clk_ctrl_rdata_o is always zero.
- R10: On bit 4, a clock-control write overrides a set or clear pulse that arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_set_i | input | 13 | Per-source set pulses |
| req_clr_i | input | 13 | Per-source clear pulses |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 32 | Mask write data |
| clk_ctrl_we_i | input | 1 | Clock control write strobe |
| clk_ctrl_wdata_i | input | 32 | Clock control data (bit 0 stop, bit 1 start) |
| clk_ctrl_rdata_o | output | 32 | Clock control read data, always zero |
| dma_en_i | input | 1 | DMA mode enable |
| req_o | output | 13 | Pending request vector |
| mask_o | output | 13 | Stored mask |
| clk_en_o | output | 1 | Clock-enabled status |
| xfer_abort_o | output | 1 | One-cycle transfer abort pulse |
| irq_o | output | 1 | CPU interrupt |
| rx_dma_req_o | output | 1 | Receive DMA request |
| tx_dma_req_o | output | 1 | Transmit DMA request |

## Verification
The bench toggles DMA mode while the FIFO requests are pending. A router that kept those two bits on the CPU line in DMA mode would raise irq_o at the wrong time. One that left the DMA lines live with DMA off would drive spurious transfers. It also lands set and clear pulses in the same cycle, and it lands clock-control writes on top of clock-off pulses. A wrong precedence there leaves a stale or lost pending bit. Mask writes carry junk in the upper bits, and stop and start are written together. A wrong decode would show as a corrupted mask or as a clock left running after a stop.

// File: rtl/mci_irq_pkg.sv
package mci_irq_pkg;
  localparam int NUM_SRC   = 13;
  localparam int REG_W     = 32;
  localparam int SRC_CLK_OFF = 4;
  localparam int SRC_RX_REQ  = 5;
  localparam int SRC_TX_REQ  = 6;
  localparam int CTL_STOP_BIT  = 0;
  localparam int CTL_START_BIT = 1;
  localparam logic [NUM_SRC-1:0] DMA_STEER_MASK =
    NUM_SRC'((1 << SRC_RX_REQ) | (1 << SRC_TX_REQ));

  typedef struct packed {
    logic start;
    logic stop;
  } clk_cmd_t;
endpackage

// File: rtl/mci_req_bank.sv
module mci_req_bank
  import mci_irq_pkg::*;
#(
  parameter int N = NUM_SRC,
  parameter int OVR_BIT = SRC_CLK_OFF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         ovr_set_i,
  input  logic         ovr_clr_i,
  output logic [N-1:0] req_o
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    logic q;
    logic d;
    if (k == OVR_BIT) begin : g_ovr
      // clock control beats the pulses on this bit
      always_comb begin
        if (ovr_set_i)      d = 1'b1;
        else if (ovr_clr_i) d = 1'b0;
        else if (set_i[k])  d = 1'b1;
        else if (clr_i[k])  d = 1'b0;
        else                d = q;
      end
    end else begin : g_std
      always_comb begin
        if (set_i[k])      d = 1'b1;
        else if (clr_i[k]) d = 1'b0;
        else               d = q;
      end
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= d;
    end
    assign req_o[k] = q;
  end
endmodule

// File: rtl/mci_clk_ctrl.sv
module mci_clk_ctrl
  import mci_irq_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output clk_cmd_t     cmd_o,
  output logic         clk_en_o,
  output logic         abort_o
);
  logic unused_hi;
  assign unused_hi = ^{wdata_i[W-1:CTL_START_BIT+1]};

  always_comb begin
    cmd_o.stop  = we_i & wdata_i[CTL_STOP_BIT];
    cmd_o.start = we_i & wdata_i[CTL_START_BIT] & ~cmd_o.stop;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_en_o <= 1'b0;
      abort_o  <= 1'b0;
    end else begin
      abort_o <= cmd_o.stop;
      if (cmd_o.stop)       clk_en_o <= 1'b0;
      else if (cmd_o.start) clk_en_o <= 1'b1;
    end
  end
endmodule

// File: rtl/mci_irq_steer.sv
module mci_irq_steer
  import mci_irq_pkg::*;
#(
  parameter int N = NUM_SRC,
  parameter int W = REG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         mask_we_i,
  input  logic [W-1:0] mask_wdata_i,
  input  logic [N-1:0] req_i,
  input  logic         dma_en_i,
  output logic [N-1:0] mask_o,
  output logic         irq_o,
  output logic         rx_dma_o,
  output logic         tx_dma_o
);
  logic unused_hi;
  logic [N-1:0] eff_mask;
  assign unused_hi = ^{mask_wdata_i[W-1:N]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_o <= '0;
    else if (mask_we_i) mask_o <= mask_wdata_i[N-1:0];
  end

  assign eff_mask = dma_en_i ? (mask_o | DMA_STEER_MASK) : mask_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o    <= 1'b0;
      rx_dma_o <= 1'b0;
      tx_dma_o <= 1'b0;
    end else begin
      irq_o    <= |(req_i & ~eff_mask);
      rx_dma_o <= dma_en_i & req_i[SRC_RX_REQ];
      tx_dma_o <= dma_en_i & req_i[SRC_TX_REQ];
    end
  end
endmodule

// File: rtl/mci_irq_router.sv
module mci_irq_router
  import mci_irq_pkg::*;
#(
  parameter int N = NUM_SRC,
  parameter int W = REG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_set_i,
  input  logic [N-1:0] req_clr_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] mask_wdata_i,
  input  logic         clk_ctrl_we_i,
  input  logic [W-1:0] clk_ctrl_wdata_i,
  output logic [W-1:0] clk_ctrl_rdata_o,
  input  logic         dma_en_i,
  output logic [N-1:0] req_o,
  output logic [N-1:0] mask_o,
  output logic         clk_en_o,
  output logic         xfer_abort_o,
  output logic         irq_o,
  output logic         rx_dma_req_o,
  output logic         tx_dma_req_o
);
  clk_cmd_t clk_cmd;

  assign clk_ctrl_rdata_o = '0;

  mci_clk_ctrl #(.W(W)) u_clk_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (clk_ctrl_we_i),
    .wdata_i  (clk_ctrl_wdata_i),
    .cmd_o    (clk_cmd),
    .clk_en_o (clk_en_o),
    .abort_o  (xfer_abort_o)
  );

  mci_req_bank #(.N(N), .OVR_BIT(SRC_CLK_OFF)) u_req_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (req_set_i),
    .clr_i     (req_clr_i),
    .ovr_set_i (clk_cmd.stop),
    .ovr_clr_i (clk_cmd.start),
    .req_o     (req_o)
  );

  mci_irq_steer #(.N(N), .W(W)) u_steer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mask_we_i    (mask_we_i),
    .mask_wdata_i (mask_wdata_i),
    .req_i        (req_o),
    .dma_en_i     (dma_en_i),
    .mask_o       (mask_o),
    .irq_o        (irq_o),
    .rx_dma_o     (rx_dma_req_o),
    .tx_dma_o     (tx_dma_req_o)
  );
endmodule

// File: rtl/mci_irq_router_chk.sv
module mci_irq_router_chk
  import mci_irq_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] req_set_i,
  input logic               clk_ctrl_we_i,
  input logic [REG_W-1:0]   clk_ctrl_wdata_i,
  input logic               dma_en_i,
  input logic [NUM_SRC-1:0] req_o,
  input logic [NUM_SRC-1:0] mask_o,
  input logic               clk_en_o,
  input logic               xfer_abort_o,
  input logic               irq_o,
  input logic               rx_dma_req_o,
  input logic               tx_dma_req_o
);
  localparam logic [NUM_SRC-1:0] NO_CLK_OFF = ~(NUM_SRC'(1) << SRC_CLK_OFF);

  AST_SET_VISIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(req_set_i & NO_CLK_OFF) |=> ((req_o & $past(req_set_i & NO_CLK_OFF)) == $past(req_set_i & NO_CLK_OFF))); // R2

  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_en_i |=> (irq_o == $past(|(req_o & ~mask_o)))); // R4

  AST_DMA_STEER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_en_i |=> (irq_o == $past(|(req_o & ~mask_o & ~DMA_STEER_MASK)))
                 && (rx_dma_req_o == $past(req_o[SRC_RX_REQ]))
                 && (tx_dma_req_o == $past(req_o[SRC_TX_REQ]))); // R5

  AST_DMA_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_en_i |=> !rx_dma_req_o && !tx_dma_req_o); // R6

  AST_CLK_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_ctrl_we_i && clk_ctrl_wdata_i[CTL_START_BIT] && !clk_ctrl_wdata_i[CTL_STOP_BIT])
    |=> clk_en_o && !req_o[SRC_CLK_OFF] && !xfer_abort_o); // R7

  AST_CLK_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_ctrl_we_i && clk_ctrl_wdata_i[CTL_STOP_BIT])
    |=> !clk_en_o && req_o[SRC_CLK_OFF] && xfer_abort_o); // R8

  AST_ABORT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_abort_o |-> $past(clk_ctrl_we_i && clk_ctrl_wdata_i[CTL_STOP_BIT])); // R8
endmodule

bind mci_irq_router mci_irq_router_chk u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .req_set_i        (req_set_i),
  .clk_ctrl_we_i    (clk_ctrl_we_i),
  .clk_ctrl_wdata_i (clk_ctrl_wdata_i),
  .dma_en_i         (dma_en_i),
  .req_o            (req_o),
  .mask_o           (mask_o),
  .clk_en_o         (clk_en_o),
  .xfer_abort_o     (xfer_abort_o),
  .irq_o            (irq_o),
  .rx_dma_req_o     (rx_dma_req_o),
  .tx_dma_req_o     (tx_dma_req_o)
);

// File: tb/mci_irq_router_bench.sv
module mci_irq_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] set_p = '0, clr_p = '0;
  logic        mask_we = 1'b0, ctl_we = 1'b0, dma_en = 1'b0;
  logic [31:0] mask_wd = '0, ctl_wd = '0;
  logic [31:0] ctl_rd;
  logic [12:0] req, mask;
  logic        clk_en, abort_p, irq, rx_dma, tx_dma;

  int vectors = 0, errors = 0;
  bit done = 0;

  // reference state
  bit [12:0] m_req, m_mask;
  bit        m_clk_en, m_abort, m_irq, m_rx, m_tx;

  always #5 clk = ~clk;

  mci_irq_router u_mci_irq_router (
    .clk_i(clk), .rst_ni(rst_n), .req_set_i(set_p), .req_clr_i(clr_p),
    .mask_we_i(mask_we), .mask_wdata_i(mask_wd),
    .clk_ctrl_we_i(ctl_we), .clk_ctrl_wdata_i(ctl_wd), .clk_ctrl_rdata_o(ctl_rd),
    .dma_en_i(dma_en), .req_o(req), .mask_o(mask), .clk_en_o(clk_en),
    .xfer_abort_o(abort_p), .irq_o(irq), .rx_dma_req_o(rx_dma), .tx_dma_req_o(tx_dma)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_req = '0; m_mask = '0; m_clk_en = 0; m_abort = 0;
      m_irq = 0; m_rx = 0; m_tx = 0;
    end else begin
      bit [12:0] hide;
      hide   = m_mask | (dma_en ? 13'h060 : 13'h000);
      m_irq  = (m_req & ~hide) != 0;
      m_rx   = dma_en && m_req[5];
      m_tx   = dma_en && m_req[6];
      for (int k = 0; k < 13; k++) begin
        if (set_p[k])      m_req[k] = 1;
        else if (clr_p[k]) m_req[k] = 0;
      end
      m_abort = 0;
      if (ctl_we && ctl_wd[0]) begin
        m_req[4] = 1; m_clk_en = 0; m_abort = 1;
      end else if (ctl_we && ctl_wd[1]) begin
        m_req[4] = 0; m_clk_en = 1;
      end
      if (mask_we) m_mask = mask_wd[12:0];
    end
  end

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare every output every cycle, away from the edge
  always @(negedge clk) if (!done) begin
    chk("R2 req_o", int'(req), int'(m_req));
    chk("R3 mask_o", int'(mask), int'(m_mask));
    chk("R4 irq_o", int'(irq), int'(m_irq));
    chk("R6 rx_dma_req_o", int'(rx_dma), int'(m_rx));
    chk("R6 tx_dma_req_o", int'(tx_dma), int'(m_tx));
    chk("R7 clk_en_o", int'(clk_en), int'(m_clk_en));
    chk("R8 xfer_abort_o", int'(abort_p), int'(m_abort));
    chk("R9 clk_ctrl_rdata_o", int'(ctl_rd), 0);
  end

  task automatic idle();
    set_p = '0; clr_p = '0; mask_we = 0; ctl_we = 0;
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
    #1 idle();
  endtask

  initial begin
    #200000;
    $display("FAIL watchdog expired actual=0 expected=1");
    errors++;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #23;
    // R1: reset state
    chk("R1 req", int'(req), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 mask", int'(mask), 0);
    chk("R1 clk_en", int'(clk_en), 0);
    @(negedge clk); #1 rst_n = 1;
    step(2);
    // R3: upper mask bits discarded
    mask_we = 1; mask_wd = 32'hFFFF_E0A5; step(2);
    chk("R3 mask low bits", int'(mask), 13'h00A5);
    // R2, R4: set unmasked source, then masked source
    set_p = 13'h0002; step(1);
    step(1); chk("R4 irq unmasked", int'(irq), 1);
    clr_p = 13'h0002; set_p = 13'h0001; step(2);
    chk("R4 irq masked only", int'(irq), 0);
    // R2: set and clear in same cycle, set wins
    set_p = 13'h0100; clr_p = 13'h0100; step(1);
    chk("R2 set wins", int'(req[8]), 1);
    clr_p = 13'h1FFF; step(2);
    chk("R2 clear all", int'(req), 0);
    // R5, R6: FIFO requests with DMA on and off
    mask_we = 1; mask_wd = 0; set_p = 13'h0060; step(2);
    chk("R4 fifo irq dma off", int'(irq), 1);
    chk("R6 dma low when off", int'(rx_dma | tx_dma), 0);
    dma_en = 1; step(1);
    chk("R5 fifo hidden", int'(irq), 0);
    chk("R6 rx dma", int'(rx_dma), 1);
    chk("R6 tx dma", int'(tx_dma), 1);
    clr_p = 13'h0020; step(2);
    chk("R6 rx drop", int'(rx_dma), 0);
    dma_en = 0; step(1);
    chk("R6 tx off", int'(tx_dma), 0);
    clr_p = 13'h1FFF; step(2);
    // R7, R8: start, stop, both
    ctl_we = 1; ctl_wd = 32'h2; step(1);
    chk("R7 clk_en set", int'(clk_en), 1);
    ctl_we = 1; ctl_wd = 32'h3; step(1);
    chk("R8 stop wins", int'(clk_en), 0);
    chk("R8 clock-off set", int'(req[4]), 1);
    chk("R8 abort pulse", int'(abort_p), 1);
    step(1); chk("R8 abort one cycle", int'(abort_p), 0);
    // R10: clock control beats pulses on bit 4
    ctl_we = 1; ctl_wd = 32'h2; set_p = 13'h0010; step(1);
    chk("R10 start beats set", int'(req[4]), 0);
    ctl_we = 1; ctl_wd = 32'h1; clr_p = 13'h0010; step(1);
    chk("R10 stop beats clear", int'(req[4]), 1);
    step(2);
    // randomized traffic, reference model checks each cycle
    for (int i = 0; i < 3000; i++) begin
      set_p   = 13'($urandom) & 13'($urandom) & 13'($urandom);
      clr_p   = 13'($urandom) & 13'($urandom) & 13'($urandom);
      mask_we = ($urandom % 8) == 0;
      mask_wd = $urandom;
      ctl_we  = ($urandom % 10) == 0;
      ctl_wd  = $urandom;
      if (($urandom % 16) == 0) dma_en = ~dma_en;
      @(negedge clk); #1;
    end
    idle(); step(3);
    // R1: asynchronous reset mid-run
    #2 rst_n = 0; #1;
    chk("R1 async req", int'(req), 0);
    chk("R1 async irq", int'(irq | rx_dma | tx_dma), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule